// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives three divided clocks from one source clock: bank A, bank B and a feedback bank. Each bank has its own select code that picks a divide ratio from a fixed, non-uniform table. Each bank drives a true output and a complement output. All ratios are even, so every output has a 50 percent duty cycle. The source clock comes from a two-level clock selector. The first level picks one of two reference clocks, a differential-receiver reference or a single-ended reference. The second level then picks either that reference or a high-rate oscillator clock. The second level lets the divider chain run directly from the reference while the oscillator path is under test or has not settled.

An active-high master reset acts at once, without waiting for a clock edge. While it is high, every bank counter is cleared, every true output is low and every complement output is high. On the first source edge after the reset is released, all three true outputs rise together. From then on each bank toggles its output every half-ratio source cycles. The banks therefore share a rising edge at the start and again at every common multiple of their periods. A ratio change made while the block is running is picked up only when that bank's output next toggles. No level is ever shorter than half of either the old ratio or the new ratio.

Top module: `clk_bank_divider`

## Requirements
- R1: With the oscillator path deselected (`bypassSel`=0), `refSel`=0 routes `refDiffClk` to the dividers and `refSel`=1 routes `refSeClk`.
- R2: `bypassSel`=1 routes `oscClk` to the dividers whatever `refSel` holds; `bypassSel`=0 routes the chosen reference.
- R3: Bank A ratio from `divSelA`: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 6, 2'b11 gives 8.
- R4: Bank B ratio from `divSelB`: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8, 2'b11 gives 12.
- R5: Feedback ratio from `divSelFb`: 3'b000 gives 4, 001 gives 6, 010 gives 8, 011 gives 10, 100 gives 8, 101 gives 12, 110 gives 16, 111 gives 20.
- R6: While `mrst` is high, all true outputs are 0 and all complement outputs are 1, at once and with no source edge needed.
- R7: While running, each true output has a period of exactly ratio source cycles and is high for exactly ratio/2 of them.
- R8: On the first rising source edge after `mrst` falls, all three true outputs go high together.
- R9: A select change while running takes effect at that bank's next output toggle. Every level lasts ratio/2 source cycles of either the old or the new ratio, never less.
- R10: Each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock, picked when bypassSel=1 |
| refDiffClk | input | 1 | Reference clock from the differential receiver |
| refSeClk | input | 1 | Single-ended reference clock |
| refSel | input | 1 | 0 picks refDiffClk, 1 picks refSeClk |
| bypassSel | input | 1 | 0 picks the chosen reference, 1 picks oscClk |
| mrst | input | 1 | Active-high asynchronous master reset |
| divSelA | input | 2 | Bank A ratio select |
| divSelB | input | 2 | Bank B ratio select |
| divSelFb | input | 3 | Feedback bank ratio select |
| qA | output | 1 | Bank A true output |
| qAn | output | 1 | Bank A complement output |
| qB | output | 1 | Bank B true output |
| qBn | output | 1 | Bank B complement output |
| qFb | output | 1 | Feedback true output |
| qFbn | output | 1 | Feedback complement output |

## Verification
The bench builds the block with its default ratio ceiling of 20. This gives a 4-bit half-period counter, so the largest feedback ratio reaches the counter's top value of 9 and a limit that is one too short or one too long shows up directly. Every select code of every bank is swept on the oscillator path. All three source routings are told apart by measured period in nanoseconds, because the three source clocks have distinct periods. A behavioural model checks every source cycle, including the level that straddles a mid-run ratio change.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int NUM_BANKS = 3;
  localparam int BANK_A    = 0;
  localparam int BANK_B    = 1;
  localparam int BANK_FB   = 2;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 20;
  localparam int CNT_W     = $clog2(MAX_RATIO / 2);

  typedef logic [NUM_BANKS-1:0][SEL_W-1:0] selVec_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] restart;
    logic [NUM_BANKS-1:0] toggle;
  } divStrobe_t;

  function automatic logic [CNT_W-1:0] halfLimit(input int bank, input logic [SEL_W-1:0] sel);
    int ratio;
    ratio = 2;
    case (bank)
      BANK_A: begin
        case (sel[1:0])
          2'b00:   ratio = 2;
          2'b01:   ratio = 4;
          2'b10:   ratio = 6;
          default: ratio = 8;
        endcase
      end
      BANK_B: begin
        case (sel[1:0])
          2'b00:   ratio = 2;
          2'b01:   ratio = 4;
          2'b10:   ratio = 8;
          default: ratio = 12;
        endcase
      end
      default: begin
        case (sel)
          3'b000:  ratio = 4;
          3'b001:  ratio = 6;
          3'b010:  ratio = 8;
          3'b011:  ratio = 10;
          3'b100:  ratio = 8;
          3'b101:  ratio = 12;
          3'b110:  ratio = 16;
          default: ratio = 20;
        endcase
      end
    endcase
    return CNT_W'(ratio / 2 - 1);
  endfunction
endpackage

// File: rtl/cbd_src_mux.sv
module cbd_src_mux (
  input  logic oscClk,
  input  logic refDiffClk,
  input  logic refSeClk,
  input  logic refSel,
  input  logic bypassSel,
  output logic srcClk
);
  logic refClk;

  // R1: first level picks the reference
  assign refClk = refSel ? refSeClk : refDiffClk;
  // R2: second level picks oscillator or reference
  assign srcClk = bypassSel ? oscClk : refClk;
endmodule

// File: rtl/cbd_div_ctrl.sv
module cbd_div_ctrl
  import cbd_pkg::*;
(
  input  logic       srcClk,
  input  logic       mrst,
  input  selVec_t    selVec,
  output divStrobe_t strobe
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;
    logic             running;

    always_ff @(posedge srcClk or posedge mrst) begin
      if (mrst) begin
        count   <= '0;
        limit   <= '0;
        running <= 1'b0;
      end else if (!running) begin
        running <= 1'b1;
        count   <= '0;
        limit   <= halfLimit(b, selVec[b]);
      end else if (count == limit) begin
        count   <= '0;
        limit   <= halfLimit(b, selVec[b]);   // R9: new ratio at toggle boundary
      end else begin
        count   <= count + CNT_W'(1);
      end
    end

    assign strobe.restart[b] = !running;
    assign strobe.toggle[b]  = running && (count == limit);

    // R7: the half-period counter never passes its captured limit
    p_count_bound_r7: assert property (@(posedge srcClk) disable iff (mrst)
      count <= limit);
  end

  // R8: all banks leave reset on the same source edge
  p_common_start_r8: assert property (@(posedge srcClk) disable iff (mrst)
    (strobe.restart == '0) || (strobe.restart == '1));
endmodule

// File: rtl/cbd_div_out.sv
module cbd_div_out
  import cbd_pkg::*;
(
  input  logic                 srcClk,
  input  logic                 mrst,
  input  divStrobe_t           strobe,
  output logic [NUM_BANKS-1:0] qTrue,
  output logic [NUM_BANKS-1:0] qComp
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge srcClk or posedge mrst) begin
      if (mrst)                   qTrue[b] <= 1'b0;
      else if (strobe.restart[b]) qTrue[b] <= 1'b1;
      else if (strobe.toggle[b])  qTrue[b] <= ~qTrue[b];
    end

    // R8: a restart strobe lands as a high output
    p_start_high_r8: assert property (@(posedge srcClk) disable iff (mrst)
      strobe.restart[b] |=> qTrue[b]);
    // R7: a toggle strobe always flips the output
    p_toggle_flip_r7: assert property (@(posedge srcClk) disable iff (mrst)
      strobe.toggle[b] |=> (qTrue[b] != $past(qTrue[b])));
    // R9: no toggle without a strobe, so no runt level
    p_hold_level_r9: assert property (@(posedge srcClk) disable iff (mrst)
      (!strobe.toggle[b] && !strobe.restart[b]) |=> $stable(qTrue[b]));
  end

  assign qComp = ~qTrue;  // R10
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
  import cbd_pkg::*;
(
  input  logic       oscClk,
  input  logic       refDiffClk,
  input  logic       refSeClk,
  input  logic       refSel,
  input  logic       bypassSel,
  input  logic       mrst,
  input  logic [1:0] divSelA,
  input  logic [1:0] divSelB,
  input  logic [2:0] divSelFb,
  output logic       qA,
  output logic       qAn,
  output logic       qB,
  output logic       qBn,
  output logic       qFb,
  output logic       qFbn
);
  logic                 srcClk;
  selVec_t              selVec;
  divStrobe_t           strobe;
  logic [NUM_BANKS-1:0] qTrue;
  logic [NUM_BANKS-1:0] qComp;

  assign selVec[BANK_A]  = SEL_W'(divSelA);
  assign selVec[BANK_B]  = SEL_W'(divSelB);
  assign selVec[BANK_FB] = SEL_W'(divSelFb);

  cbd_src_mux u_mux (
    .oscClk(oscClk), .refDiffClk(refDiffClk), .refSeClk(refSeClk),
    .refSel(refSel), .bypassSel(bypassSel), .srcClk(srcClk)
  );

  cbd_div_ctrl u_ctrl (
    .srcClk(srcClk), .mrst(mrst), .selVec(selVec), .strobe(strobe)
  );

  cbd_div_out u_out (
    .srcClk(srcClk), .mrst(mrst), .strobe(strobe), .qTrue(qTrue), .qComp(qComp)
  );

  assign qA   = qTrue[BANK_A];
  assign qAn  = qComp[BANK_A];
  assign qB   = qTrue[BANK_B];
  assign qBn  = qComp[BANK_B];
  assign qFb  = qTrue[BANK_FB];
  assign qFbn = qComp[BANK_FB];
endmodule

// File: tb/clk_bank_divider_test.sv
module clk_bank_divider_test;
  logic oscClk = 0, refDiffClk = 0, refSeClk = 0;
  always #4  oscClk     = ~oscClk;      // 125 MHz
  always #8  refDiffClk = ~refDiffClk;  // 16 ns
  always #12 refSeClk   = ~refSeClk;    // 24 ns

  logic       refSel = 0, bypassSel = 1, mrst = 1;
  logic [1:0] selA = 0, selB = 0;
  logic [2:0] selFb = 0;
  wire qA, qAn, qB, qBn, qFb, qFbn;

  clk_bank_divider uut (
    .oscClk(oscClk), .refDiffClk(refDiffClk), .refSeClk(refSeClk),
    .refSel(refSel), .bypassSel(bypassSel), .mrst(mrst),
    .divSelA(selA), .divSelB(selB), .divSelFb(selFb),
    .qA(qA), .qAn(qAn), .qB(qB), .qBn(qBn), .qFb(qFb), .qFbn(qFbn)
  );

  wire benchSrc = bypassSel ? oscClk : (refSel ? refSeClk : refDiffClk);

  int checks = 0, failures = 0;
  bit finished = 0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic int ratioOf(int b);
    if (b == 0) begin
      case (selA) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
    end else if (b == 1) begin
      case (selB) 2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 12; endcase
    end
    case (selFb)
      3'd0: return 4;  3'd1: return 6;  3'd2: return 8;  3'd3: return 10;
      3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
    endcase
  endfunction

  function automatic bit outOf(int b);
    return (b == 0) ? qA : ((b == 1) ? qB : qFb);
  endfunction

  // Behavioural model: cycles remaining until the next level change
  bit mLvl[3];
  bit mRun[3];
  int mRem[3];
  always @(posedge benchSrc or posedge mrst) begin
    for (int b = 0; b < 3; b++) begin
      if (mrst) begin
        mLvl[b] = 0; mRun[b] = 0; mRem[b] = 0;
      end else if (!mRun[b]) begin
        mLvl[b] = 1; mRun[b] = 1; mRem[b] = ratioOf(b) / 2;
      end else begin
        mRem[b] = mRem[b] - 1;
        if (mRem[b] == 0) begin
          mLvl[b] = ~mLvl[b];
          mRem[b] = ratioOf(b) / 2;
        end
      end
    end
  end

  always @(negedge benchSrc) begin
    if (!finished) begin
      chk(qA == mLvl[0],  "R3", "model bank A level", int'(qA), int'(mLvl[0]));
      chk(qB == mLvl[1],  "R4", "model bank B level", int'(qB), int'(mLvl[1]));
      chk(qFb == mLvl[2], "R5", "model feedback level", int'(qFb), int'(mLvl[2]));
      chk({qAn, qBn, qFbn} == ~{qA, qB, qFb}, "R10", "complement pairs",
          int'({qAn, qBn, qFbn}), int'(~{qA, qB, qFb}));
    end
  end

  task automatic checkResetState(string ctx);
    chk({qA, qB, qFb} == 3'b000, "R6", {ctx, " true outputs in reset"}, int'({qA, qB, qFb}), 0);
    chk({qAn, qBn, qFbn} == 3'b111, "R6", {ctx, " complement outputs in reset"}, int'({qAn, qBn, qFbn}), 7);
  endtask

  task automatic setup(bit bp, bit rs, logic [1:0] a, logic [1:0] b, logic [2:0] fb);
    @(negedge benchSrc); #1;
    mrst = 1; bypassSel = bp; refSel = rs; selA = a; selB = b; selFb = fb;
    #30;
    checkResetState("setup");
    @(negedge benchSrc); #1;
    mrst = 0;
    @(negedge benchSrc);
    chk({qA, qB, qFb} == 3'b111, "R8", "all banks high on first edge", int'({qA, qB, qFb}), 7);
  endtask

  task automatic measure(int b, int expN, string req);
    bit prev, cur;
    int hi = 0, per = 0, guard = 0;
    prev = outOf(b);
    forever begin
      @(negedge benchSrc); cur = outOf(b); guard++;
      if ((!prev && cur) || guard > 400) break;
      prev = cur;
    end
    hi = 1;
    forever begin
      @(negedge benchSrc); guard++;
      if (!outOf(b) || guard > 400) break;
      hi++;
    end
    per = hi + 1;
    forever begin
      @(negedge benchSrc); guard++;
      if (outOf(b) || guard > 400) break;
      per++;
    end
    chk(hi == expN / 2, req, $sformatf("bank %0d high time", b), hi, expN / 2);
    chk(per == expN, "R7", $sformatf("bank %0d period", b), per, expN);
  endtask

  task automatic periodNs(int expNs, string req);
    time t0, t1;
    bit prev;
    int guard = 0;
    prev = qA;
    forever begin @(negedge benchSrc); guard++; if ((!prev && qA) || guard > 100) break; prev = qA; end
    t0 = $time; prev = qA;
    forever begin @(negedge benchSrc); guard++; if ((!prev && qA) || guard > 200) break; prev = qA; end
    t1 = $time;
    chk((t1 - t0) == expNs, req, "bank A period in ns", int'(t1 - t0), expNs);
  endtask

  initial begin
    // reset state at start
    #20;
    checkResetState("power-up");

    // R3, R4, R5, R7: every select code on the oscillator path
    for (int code = 0; code < 8; code++) begin
      setup(1'b1, 1'b0, 2'(code % 4), 2'(code % 4), 3'(code));
      measure(0, ratioOf(0), "R3");
      measure(1, ratioOf(1), "R4");
      measure(2, ratioOf(2), "R5");
    end

    // R1, R2: source routing told apart by period in ns (ratio 2)
    setup(1'b1, 1'b0, 2'b00, 2'b00, 3'b000); periodNs(16, "R2");
    setup(1'b1, 1'b1, 2'b00, 2'b00, 3'b000); periodNs(16, "R2");
    setup(1'b0, 1'b0, 2'b00, 2'b00, 3'b000); periodNs(32, "R1");
    setup(1'b0, 1'b1, 2'b00, 2'b00, 3'b000); periodNs(48, "R1");
    measure(1, 2, "R4");

    // R9: ratio change while running
    setup(1'b1, 1'b0, 2'b00, 2'b01, 3'b000);
    repeat (5) @(negedge benchSrc);
    #1 selFb = 3'b111; selA = 2'b11;
    begin
      int len = 0;
      bit start;
      @(negedge benchSrc); start = qFb;
      forever begin @(negedge benchSrc); if (qFb != start) break; end
      len = 1;
      forever begin @(negedge benchSrc); if (qFb == start || len > 40) break; len++; end
      chk(len == 2 || len == 10, "R9", "first full level after change", len, 10);
    end
    measure(2, 20, "R9");
    measure(0, 8, "R9");

    // R6: asynchronous reset while running, no clock edge needed
    setup(1'b1, 1'b0, 2'b10, 2'b11, 3'b101);
    repeat (9) @(negedge benchSrc);
    #1 mrst = 1;
    #1 checkResetState("mid-run async");
    #40 checkResetState("held");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule